// File: doc/BRIEF.md
# Remapping Unit Command/Status Controller

This block is the command and status front end of an I/O remapping unit. Software writes a 32-bit command word that holds three requests. One enables queued invalidation. One enables interrupt remapping. The third is a one-shot request to load the interrupt table pointer. The block carries out each request and reports the result in a separate status word. It also holds a table base address register. The value of that register is copied into the active table pointer when the load request is carried out.

Interrupt requests reach the block over a valid/ready handshake and a separate completion pulse, and an in-flight counter tracks them. A command that changes the remapping state or loads the table pointer must wait until no request is in flight. The block stops accepting requests while such a command waits, so each interrupt is handled wholly under the old setting or wholly under the new one. Each write to the command register counts as one command. A write that arrives while a command is waiting goes into a single hold slot and is carried out afterwards.

Top module: `remap_cmd_ctrl`

## Requirements
- R1: After reset the three status outputs are 0, `table_ptr` is 0, `irq_ready` is 1, and reads at offsets 0x18, 0x1C and 0x20 return 0.
- R2: A command write with bit 26 set turns on `qi_on`, and with bit 26 clear turns it off. When no drain is needed, the new value is visible in the cycle after the cycle that follows the write edge.
- R3: Bit 25 of a command write sets `remap_on` to the bit's value. A command that changes `remap_on` or has bit 24 set is applied at the first edge at which the in-flight count is zero. Until then `irq_ready` is 0 and no request is accepted.
- R4: A command write with bit 24 set copies the table address register (written at offset 0x20) into `table_ptr` at the apply edge. `ptr_valid` rises one cycle after that.
- R5: A command write with bit 24 clear leaves `table_ptr` and `ptr_valid` unchanged.
- R6: When `remap_on` falls, `ptr_valid` is 0 in that same cycle. If the same command has bit 24 set, `ptr_valid` rises again one cycle later.
- R7: The in-flight count rises on each accepted request (`irq_valid` and `irq_ready` both 1) and falls on each `irq_done`. An `irq_done` while the count is zero is ignored. `irq_ready` is 0 while the count is at its maximum of 2^CNT_W-1.
- R8: A read at offset 0x18 returns 0. A read at 0x1C returns `qi_on` in bit 26, `remap_on` in bit 25, `ptr_valid` in bit 24, and zeros elsewhere. A read at 0x20 returns the table address register.
- R9: When a feature is configured as absent, its command bits are ignored and its status stays 0. With `SUP_IR` = 0 this covers both bit 25 and bit 24.
- R10: A command write that arrives while another command is waiting goes to a one-entry hold slot, and a later write overwrites the slot. The held command is taken up after the waiting one has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | 32 | Combinational read data |
| irq_valid | input | 1 | Interrupt request offered |
| irq_ready | output | 1 | Interrupt request may be accepted |
| irq_done | input | 1 | One in-flight request has completed |
| qi_on | output | 1 | Queued invalidation status |
| remap_on | output | 1 | Interrupt remapping status |
| ptr_valid | output | 1 | Table pointer loaded status |
| table_ptr | output | 32 | Active interrupt table pointer |

## Verification
Two events can fall on the same edge: a command write and a request accept, or a command write and a completion. The bench provokes this by driving `wr_en` and `irq_valid` together in one cycle. Because the request is accepted on that edge, the remapping change must wait for that request's `irq_done`. The bench judges this by watching `remap_on` stay put until one cycle after the completion. A second collision happens when a held command is taken up on the edge just after the waiting command is applied. Here the bench checks the order of the status changes and confirms that an overwritten held write leaves no trace in `table_ptr`.

// File: rtl/remap_cmd_ctrl.sv
module remap_cmd_ctrl #(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 4,
  parameter bit SUP_QI = 1'b1,
  parameter bit SUP_IR = 1'b1,
  parameter logic [ADDR_W-1:0] CMD_OFF = ADDR_W'('h18),
  parameter logic [ADDR_W-1:0] STS_OFF = ADDR_W'('h1C),
  parameter logic [ADDR_W-1:0] TAB_OFF = ADDR_W'('h20)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              irq_valid,
  output logic              irq_ready,
  input  logic              irq_done,
  output logic              qi_on,
  output logic              remap_on,
  output logic              ptr_valid,
  output logic [31:0]       table_ptr
);
  localparam int QI_BIT = 26;
  localparam int IR_BIT = 25;
  localparam int TP_BIT = 24;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0]      tab_addr;
  logic [2:0]       pend_cmd, hold_cmd;
  logic             pend_vld, hold_vld;
  logic [CNT_W-1:0] inflight;
  logic             qies, ires, irtps, set_d;

  wire cmd_wr = wr_en && (wr_addr == CMD_OFF);
  wire [2:0] wr_cmd = {wr_data[QI_BIT] & SUP_QI, wr_data[IR_BIT] & SUP_IR, wr_data[TP_BIT] & SUP_IR};
  wire need_drain = pend_vld && ((pend_cmd[1] != ires) || pend_cmd[0]);
  wire apply = pend_vld && (!need_drain || (inflight == '0));
  wire ptr_load = apply && pend_cmd[0];
  wire ire_off = apply && ires && !pend_cmd[1];

  assign irq_ready = !need_drain && (inflight != CNT_MAX);
  wire acc = irq_valid && irq_ready;
  wire dec = irq_done && (inflight != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tab_addr <= '0;
    else if (wr_en && wr_addr == TAB_OFF) tab_addr <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else if (acc && !dec) inflight <= inflight + 1'b1;
    else if (dec && !acc) inflight <= inflight - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      hold_vld <= 1'b0;
      pend_cmd <= '0;
      hold_cmd <= '0;
    end else if (apply) begin
      if (hold_vld) begin
        pend_cmd <= hold_cmd;
        hold_vld <= cmd_wr;
        if (cmd_wr) hold_cmd <= wr_cmd;
      end else if (cmd_wr) begin
        pend_cmd <= wr_cmd;
      end else begin
        pend_vld <= 1'b0;
      end
    end else if (cmd_wr) begin
      if (pend_vld) begin
        hold_cmd <= wr_cmd;
        hold_vld <= 1'b1;
      end else begin
        pend_cmd <= wr_cmd;
        pend_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qies <= 1'b0;
      ires <= 1'b0;
      irtps <= 1'b0;
      set_d <= 1'b0;
      table_ptr <= '0;
    end else begin
      set_d <= ptr_load;
      if (apply) begin
        qies <= pend_cmd[2];
        ires <= pend_cmd[1];
      end
      if (ptr_load) table_ptr <= tab_addr;
      if (ire_off) irtps <= 1'b0;
      else if (set_d) irtps <= 1'b1;
    end
  end

  assign qi_on = qies;
  assign remap_on = ires;
  assign ptr_valid = irtps;

  always_comb begin
    rd_data = '0;
    if (rd_addr == STS_OFF) begin
      rd_data[QI_BIT] = qies;
      rd_data[IR_BIT] = ires;
      rd_data[TP_BIT] = irtps;
    end else if (rd_addr == TAB_OFF) begin
      rd_data = tab_addr;
    end
  end
endmodule

module remap_cmd_ctrl_chk #(
  parameter int CNT_W = 4,
  parameter bit SUP_QI = 1'b1,
  parameter bit SUP_IR = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             qies,
  input logic             ires,
  input logic             irtps,
  input logic [CNT_W-1:0] cnt,
  input logic             acc,
  input logic             dec,
  input logic             ptr_load
);
  // R3
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ires) |-> $past(cnt) == '0);
  // R7
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dec) |=> cnt == $past(cnt) + 1'b1);
  // R7
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !acc) |=> cnt == $past(cnt) - 1'b1);
  // R4
  ptr_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irtps) |-> $past(ptr_load, 2));
  // R6
  fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ires) |-> !irtps);

  always @(posedge clk) begin
    if (rst_n) begin
      // R9
      qi_absent_chk: assert (SUP_QI || !qies);
      // R9
      ir_absent_chk: assert (SUP_IR || (!ires && !irtps));
    end
  end
endmodule

bind remap_cmd_ctrl remap_cmd_ctrl_chk #(.CNT_W(CNT_W), .SUP_QI(SUP_QI), .SUP_IR(SUP_IR)) u_chk (
  .clk(clk), .rst_n(rst_n), .qies(qies), .ires(ires), .irtps(irtps),
  .cnt(inflight), .acc(acc), .dec(dec), .ptr_load(ptr_load)
);

// File: tb/remap_cmd_ctrl_tb.sv
module remap_cmd_ctrl_tb;
  localparam logic [7:0] CMD = 8'h18, STS = 8'h1C, TAB = 8'h20;
  logic clk = 0, rst_n = 0, wr_en = 0, irq_valid = 0, irq_done = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, table_ptr, ns_rd, ns_ptr;
  logic irq_ready, qi_on, remap_on, ptr_valid, ns_ready, ns_qi, ns_ir, ns_pv;
  int checks = 0, errors = 0;
  logic m_q, m_i, m_pv;
  logic [31:0] m_ptr, tab;

  always #5 clk = ~clk;

  remap_cmd_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_done(irq_done),
    .qi_on(qi_on), .remap_on(remap_on), .ptr_valid(ptr_valid), .table_ptr(table_ptr));

  remap_cmd_ctrl #(.SUP_QI(1'b0), .SUP_IR(1'b0)) u_nosup (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(ns_rd), .irq_valid(irq_valid),
    .irq_ready(ns_ready), .irq_done(irq_done), .qi_on(ns_qi), .remap_on(ns_ir), .ptr_valid(ns_pv),
    .table_ptr(ns_ptr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic push();
    @(negedge clk); irq_valid = 1;
    @(negedge clk); irq_valid = 0;
  endtask

  task automatic done();
    @(negedge clk); irq_done = 1;
    @(negedge clk); irq_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 qi", qi_on, 0); chk("R1 ir", remap_on, 0); chk("R1 pv", ptr_valid, 0);
    chk("R1 ptr", table_ptr, 0); chk("R1 ready", irq_ready, 1);
    rd_chk("R1 rd cmd", CMD, 0); rd_chk("R1 rd sts", STS, 0); rd_chk("R1 rd tab", TAB, 0);

    // R2 R4 R11-style exact timing, no drain
    wr(TAB, 32'hABCD_0040);
    rd_chk("R8 tab readback", TAB, 32'hABCD_0040);
    wr(CMD, (32'h1 << 26) | (32'h1 << 24));
    chk("R2 qi not yet", qi_on, 0); chk("R4 ptr not yet", table_ptr, 0);
    @(negedge clk);
    chk("R2 qi applied", qi_on, 1); chk("R4 ptr loaded", table_ptr, 32'hABCD_0040);
    chk("R4 pv lags", ptr_valid, 0);
    @(negedge clk);
    chk("R4 pv set", ptr_valid, 1);
    rd_chk("R8 rd cmd zero", CMD, 0);
    m_q = 1; m_i = 0; m_pv = 1; m_ptr = 32'hABCD_0040;

    // Sweep: every prior (qi, ir) state against every 3-bit command (R2 R3 R4 R5 R6 R8 R9)
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        tab = 32'h0004_0000 + 32'((p * 8 + c) * 256);
        wr(TAB, tab);
        wr(CMD, (32'(p[1]) << 26) | (32'(p[0]) << 25));
        repeat (3) @(negedge clk);
        if (m_i && !p[0]) m_pv = 0;
        m_q = p[1]; m_i = p[0];
        wr(CMD, (32'(c[2]) << 26) | (32'(c[1]) << 25) | (32'(c[0]) << 24));
        repeat (3) @(negedge clk);
        if (m_i && !c[1]) m_pv = 0;
        if (c[0]) begin m_ptr = tab; m_pv = 1; end
        m_q = c[2]; m_i = c[1];
        chk("R2 sweep qi", qi_on, m_q);
        chk("R3 sweep ir", remap_on, m_i);
        chk(c[0] ? "R4 sweep ptr" : "R5 sweep ptr kept", table_ptr, m_ptr);
        chk("R6 sweep pv", ptr_valid, m_pv);
        rd_chk("R8 sweep sts", STS, (32'(m_q) << 26) | (32'(m_i) << 25) | (32'(m_pv) << 24));
        chk("R9 absent qi", ns_qi, 0); chk("R9 absent ir", ns_ir, 0);
        chk("R9 absent pv", ns_pv, 0); chk("R9 absent ptr", ns_ptr, 0);
      end
    end

    // R3 drain before enable
    wr(CMD, 0);
    repeat (3) @(negedge clk);
    push(); push(); push();
    wr(TAB, 32'h5555_0100);
    wr(CMD, (32'h1 << 25) | (32'h1 << 24));
    chk("R3 held", remap_on, 0); chk("R3 ready low", irq_ready, 0);
    irq_valid = 1;
    repeat (3) @(negedge clk);
    chk("R3 still held", remap_on, 0);
    done(); done(); done();
    chk("R3 not before boundary", remap_on, 0); chk("R3 ready low drain", irq_ready, 0);
    @(negedge clk);
    irq_valid = 0;
    chk("R3 applied after drain", remap_on, 1); chk("R3 ready back", irq_ready, 1);
    chk("R4 ptr after drain", table_ptr, 32'h5555_0100);
    @(negedge clk);
    chk("R4 pv after drain", ptr_valid, 1);

    // R7 ignored done at zero, then write and accept in the same cycle
    done();
    @(negedge clk); irq_valid = 1; wr_en = 1; wr_addr = CMD; wr_data = 0;
    @(negedge clk); irq_valid = 0; wr_en = 0;
    chk("R3 same-cycle accept waits", remap_on, 1);
    repeat (2) @(negedge clk);
    chk("R7 underflow ignored, still waits", remap_on, 1);
    done();
    chk("R3 boundary", remap_on, 1);
    @(negedge clk);
    chk("R3 disabled", remap_on, 0); chk("R6 pv cleared", ptr_valid, 0);
    chk("R5 ptr kept on disable", table_ptr, 32'h5555_0100);

    // R7 saturation
    @(negedge clk); irq_valid = 1;
    repeat (15) @(negedge clk);
    chk("R7 ready low at max", irq_ready, 0);
    irq_valid = 0;
    repeat (14) done();
    chk("R7 ready after drop", irq_ready, 1);
    done();

    // R10 hold slot with overwrite
    push();
    wr(TAB, 32'h7777_0200);
    wr(CMD, 32'h1 << 25);
    wr(CMD, (32'h1 << 26) | (32'h1 << 25) | (32'h1 << 24));
    wr(CMD, (32'h1 << 26) | (32'h1 << 25));
    chk("R10 waiting", remap_on, 0); chk("R10 qi waiting", qi_on, 0);
    done();
    chk("R10 boundary", remap_on, 0);
    @(negedge clk);
    chk("R10 first applied", remap_on, 1); chk("R10 first qi", qi_on, 0);
    @(negedge clk);
    chk("R10 held applied", qi_on, 1);
    chk("R10 overwritten write dropped", table_ptr, 32'h5555_0100);
    @(negedge clk);
    chk("R10 no pv from dropped", ptr_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule